// File: doc/BRIEF.md
# SMBus Host Transaction Controller

This block is the transaction layer of an SMBus host. Software fills a small set of byte registers: target address with direction flag, command, two data bytes, a block data port and a PEC byte. It then writes the control register with a protocol code and the start bit. The controller steps through the protocol as a series of byte-level operations (start, write byte, read byte, stop). Each operation goes to a separate bit-level engine, and the engine answers with a done pulse, an acknowledge flag, an arbitration-lost flag and a received byte.

Results land in the status register. Its flag bits are cleared by writing 1 to them. A single interrupt line is raised while any completion or error flag is set. Block transfers move one byte at a time: after every data byte the controller sets a byte-done flag and waits until software has serviced the block port and cleared that flag. A kill bit in the control register abandons a running transaction at once.

Top module: `smbus_host_ctrl`

## Requirements
- R1: Register offsets are: status 0, control 2, command 3, address 4, data0 5, data1 6, block port 7, PEC byte 8, auxiliary control 13. Command, address, data0, data1, block and PEC read back as written. Auxiliary control keeps bits 1:0 only. Control keeps bits 7 and 5:2, and its start bit 6 and kill bit 1 read as 0. Unmapped offsets read 0.
- R2: After reset every register and status bit reads 0, irq is low and no bus operation is issued.
- R3: A control write with bit 6 set and protocol field bits 4:2 equal to 0 (quick), 1 (byte), 2 (byte-data), 3 (word), 5 (block; codes 0x14 and 0x34) or 6 (I2C block; codes 0x18 and 0x38) makes status bit 0 (busy) read 1 from the next clock. The start is ignored while busy, or when the field is 4 or 7. A control write while busy leaves the control register unchanged.
- R4: Bus operations are encoded on bus_op as 0 start, 1 write byte, 2 read byte, 3 stop, with one operation outstanding at a time. The address byte is {address[7:1], rw}. The sequences are:
  - Quick: start, address, stop.
  - Byte: start, address, then the command byte (write) or one read (read), then stop.
  - Byte-data and word writes: start, address with rw=0, command, data0, and for word also data1, then stop.
  - Byte-data and word reads: start, address with rw=0, command, start, address with rw=1, one read (two for word), then stop.
- R5: A byte result goes to data0. A word result puts the low byte in data0 and the high byte in data1. The final read of a transaction is flagged with bus_rd_nack.
- R6: A transaction ends when its stop operation completes. In that same cycle busy falls and status bit 1 (complete) is set.
- R7: Block (field 5) write sends the command, then data0 as the count, then count bytes from the block port. Block read does a repeated start, reads a length byte into data0, then reads that many bytes into the block port. After each data byte, status bit 7 is set and the controller stalls until software clears it.
- R8: I2C block (field 6) takes the byte count from data0 and sends no count byte. Its first address phase always carries rw=0. A read uses data1 as the command byte, then a repeated start with rw=1. The same byte-done handshake as R7 applies.
- R9: With control bit 7 and auxiliary bit 0 both set, byte, byte-data, word and block transfers add one PEC byte before the stop. A write sends the PEC register. A read stores the byte in the PEC register and flags that read as the last one. Quick and I2C block transfers never add it.
- R10: A write operation that is not acknowledged sets status bit 2. The transaction skips the remaining bytes, issues a stop and then clears busy.
- R11: Arbitration lost on any operation sets status bit 3 and clears busy, with no stop issued.
- R12: A control write with bit 1 set while busy clears busy and sets status bit 4 on the next clock. No further bus operations follow.
- R13: Writing 1 to status bits 1, 2, 3, 4 or 7 clears them, and writing 0 leaves them unchanged. irq is high exactly while any of status bits 1 to 4 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq | output | 1 | Completion or error pending |
| bus_op_valid | output | 1 | Issues one byte-engine operation |
| bus_op | output | 2 | Operation: start, write, read, stop |
| bus_wbyte | output | 8 | Byte to transmit for write operations |
| bus_rd_nack | output | 1 | Marks the last read (master does not acknowledge) |
| bus_op_done | input | 1 | Engine finished the outstanding operation |
| bus_ack | input | 1 | Slave acknowledged the written byte |
| bus_arb_lost | input | 1 | Engine lost arbitration |
| bus_rbyte | input | 8 | Byte received by a read operation |

## Verification
Every protocol code is swept against both direction bits and both PEC settings. The complete operation trace is compared with a sequence built from the protocol rules. This separates the direction-dependent restart paths, the placement of the PEC byte, and the cases where PEC must be suppressed. Block and I2C block transfers run with one and three bytes. This tells the length-byte path apart from the count-from-data0 path, and shows that the last-read flag moves when a PEC byte follows. Separate runs inject a missing acknowledge, lost arbitration, a kill during a byte-done stall, a start while busy and an unsupported code. Each of these must leave a distinct status bit and a distinct trace tail.

// File: rtl/smbus_host_ctrl.sv
module smbus_host_ctrl #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  output logic          irq,
  output logic          bus_op_valid,
  output logic [1:0]    bus_op,
  output logic [7:0]    bus_wbyte,
  output logic          bus_rd_nack,
  input  logic          bus_op_done,
  input  logic          bus_ack,
  input  logic          bus_arb_lost,
  input  logic [7:0]    bus_rbyte
);
  localparam logic [AW-1:0] A_STS = AW'(0);
  localparam logic [AW-1:0] A_CTL = AW'(2);
  localparam logic [AW-1:0] A_CMD = AW'(3);
  localparam logic [AW-1:0] A_ADR = AW'(4);
  localparam logic [AW-1:0] A_D0  = AW'(5);
  localparam logic [AW-1:0] A_D1  = AW'(6);
  localparam logic [AW-1:0] A_BLK = AW'(7);
  localparam logic [AW-1:0] A_PEC = AW'(8);
  localparam logic [AW-1:0] A_AUX = AW'(13);
  localparam logic [7:0] CTL_KEEP = 8'hBC;
  localparam logic [2:0] P_QUICK = 3'd0, P_BYTE = 3'd1, P_WORD = 3'd3, P_BLOCK = 3'd5, P_I2C = 3'd6;
  localparam logic [1:0] OP_START = 2'd0, OP_WR = 2'd1, OP_RD = 2'd2, OP_STOP = 2'd3;

  typedef enum logic [3:0] {
    ST_IDLE, ST_START, ST_ADDR, ST_CMD, ST_RSTART, ST_RADDR, ST_CNT, ST_WDATA,
    ST_RDATA, ST_RLEN, ST_BLKW, ST_BLKR, ST_BDWAIT, ST_PEC, ST_STOP
  } state_t;

  state_t     state;
  logic [7:0] ctl_r, cmd_r, adr_r, d0_r, d1_r, blk_r, pec_r;
  logic [1:0] aux_r;
  logic       busy, f_intr, f_dev, f_bus, f_fail, f_bd;
  logic       pend, pec_act, nack_seen;
  logic [7:0] idx, cnt;

  logic [2:0] proto, wproto;
  logic       rw, ctl_wr, start_ok, kill, op_state, last_rd;
  state_t     tail_st;

  assign proto    = ctl_r[4:2];
  assign wproto   = reg_wdata[4:2];
  assign rw       = adr_r[0];
  assign ctl_wr   = reg_we && reg_addr == A_CTL;
  assign start_ok = ctl_wr && reg_wdata[6] && !busy && wproto != 3'd4 && wproto != 3'd7;
  assign kill     = ctl_wr && reg_wdata[1] && busy;
  assign op_state = state != ST_IDLE && state != ST_BDWAIT;
  assign tail_st  = pec_act ? ST_PEC : ST_STOP;
  assign last_rd  = proto != P_WORD || idx[0];
  assign irq      = f_intr | f_dev | f_bus | f_fail;
  assign bus_op_valid = busy && op_state && !pend;

  always_comb begin
    case (state)
      ST_START, ST_RSTART:        bus_op = OP_START;
      ST_STOP:                    bus_op = OP_STOP;
      ST_RDATA, ST_RLEN, ST_BLKR: bus_op = OP_RD;
      ST_PEC:                     bus_op = rw ? OP_RD : OP_WR;
      default:                    bus_op = OP_WR;
    endcase
  end

  always_comb begin
    case (state)
      ST_ADDR:  bus_wbyte = {adr_r[7:1], (proto <= P_BYTE) & rw};
      ST_CMD:   bus_wbyte = (proto == P_I2C && rw) ? d1_r : cmd_r;
      ST_RADDR: bus_wbyte = {adr_r[7:1], 1'b1};
      ST_CNT:   bus_wbyte = d0_r;
      ST_WDATA: bus_wbyte = idx[0] ? d1_r : d0_r;
      ST_BLKW:  bus_wbyte = blk_r;
      ST_PEC:   bus_wbyte = rw ? 8'h00 : pec_r;
      default:  bus_wbyte = 8'h00;
    endcase
  end

  always_comb begin
    case (state)
      ST_RDATA: bus_rd_nack = last_rd && !pec_act;
      ST_BLKR:  bus_rd_nack = (8'(idx + 8'd1) == cnt) && !pec_act;
      ST_PEC:   bus_rd_nack = rw;
      default:  bus_rd_nack = 1'b0;
    endcase
  end

  always_comb begin
    case (reg_addr)
      A_STS:   reg_rdata = {f_bd, 2'b00, f_fail, f_bus, f_dev, f_intr, busy};
      A_CTL:   reg_rdata = ctl_r;
      A_CMD:   reg_rdata = cmd_r;
      A_ADR:   reg_rdata = adr_r;
      A_D0:    reg_rdata = d0_r;
      A_D1:    reg_rdata = d1_r;
      A_BLK:   reg_rdata = blk_r;
      A_PEC:   reg_rdata = pec_r;
      A_AUX:   reg_rdata = {6'b0, aux_r};
      default: reg_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      ctl_r <= '0; cmd_r <= '0; adr_r <= '0; d0_r <= '0; d1_r <= '0;
      blk_r <= '0; pec_r <= '0; aux_r <= '0;
      busy <= 1'b0; f_intr <= 1'b0; f_dev <= 1'b0; f_bus <= 1'b0;
      f_fail <= 1'b0; f_bd <= 1'b0;
      pend <= 1'b0; pec_act <= 1'b0; nack_seen <= 1'b0;
      idx <= '0; cnt <= '0;
    end else begin
      if (reg_we) begin
        case (reg_addr)
          A_STS: begin
            f_intr <= f_intr & ~reg_wdata[1];
            f_dev  <= f_dev  & ~reg_wdata[2];
            f_bus  <= f_bus  & ~reg_wdata[3];
            f_fail <= f_fail & ~reg_wdata[4];
            f_bd   <= f_bd   & ~reg_wdata[7];
          end
          A_CTL: if (!busy) ctl_r <= reg_wdata & CTL_KEEP;
          A_CMD: cmd_r <= reg_wdata;
          A_ADR: adr_r <= reg_wdata;
          A_D0:  d0_r  <= reg_wdata;
          A_D1:  d1_r  <= reg_wdata;
          A_BLK: blk_r <= reg_wdata;
          A_PEC: pec_r <= reg_wdata;
          A_AUX: aux_r <= reg_wdata[1:0];
          default: ;
        endcase
      end

      if (kill) begin
        busy   <= 1'b0;
        f_fail <= 1'b1;
        pend   <= 1'b0;
        state  <= ST_IDLE;
      end else if (start_ok) begin
        busy      <= 1'b1;
        state     <= ST_START;
        pend      <= 1'b0;
        idx       <= '0;
        cnt       <= d0_r;
        nack_seen <= 1'b0;
        pec_act   <= reg_wdata[7] && aux_r[0] && wproto != P_QUICK && wproto != P_I2C;
      end else if (busy) begin
        if (bus_op_valid) pend <= 1'b1;
        if (state == ST_BDWAIT && !f_bd)
          state <= (idx == cnt) ? tail_st : (rw ? ST_BLKR : ST_BLKW);
        if (pend && bus_op_done) begin
          pend <= 1'b0;
          if (bus_arb_lost) begin
            busy  <= 1'b0;
            f_bus <= 1'b1;
            state <= ST_IDLE;
          end else if (bus_op == OP_WR && !bus_ack) begin
            nack_seen <= 1'b1;
            state     <= ST_STOP;
          end else begin
            case (state)
              ST_START: state <= ST_ADDR;
              ST_ADDR: begin
                if (proto == P_QUICK)            state <= ST_STOP;
                else if (proto == P_BYTE && rw)  state <= ST_RDATA;
                else                             state <= ST_CMD;
              end
              ST_CMD: begin
                if (rw && proto != P_BYTE)  state <= ST_RSTART;
                else if (proto == P_BYTE)   state <= tail_st;
                else if (proto == P_BLOCK)  state <= ST_CNT;
                else if (proto == P_I2C)    state <= (cnt == 8'd0) ? ST_STOP : ST_BLKW;
                else                        state <= ST_WDATA;
              end
              ST_RSTART: state <= ST_RADDR;
              ST_RADDR: begin
                if (proto == P_BLOCK)     state <= ST_RLEN;
                else if (proto == P_I2C)  state <= (cnt == 8'd0) ? ST_STOP : ST_BLKR;
                else                      state <= ST_RDATA;
              end
              ST_WDATA: begin
                if (proto == P_WORD && !idx[0]) idx <= 8'd1;
                else                            state <= tail_st;
              end
              ST_RDATA: begin
                if (idx[0]) d1_r <= bus_rbyte;
                else        d0_r <= bus_rbyte;
                if (proto == P_WORD && !idx[0]) idx <= 8'd1;
                else                            state <= tail_st;
              end
              ST_CNT: state <= (d0_r == 8'd0) ? tail_st : ST_BLKW;
              ST_RLEN: begin
                d0_r  <= bus_rbyte;
                cnt   <= bus_rbyte;
                state <= (bus_rbyte == 8'd0) ? tail_st : ST_BLKR;
              end
              ST_BLKW: begin
                idx   <= 8'(idx + 8'd1);
                f_bd  <= 1'b1;
                state <= ST_BDWAIT;
              end
              ST_BLKR: begin
                blk_r <= bus_rbyte;
                idx   <= 8'(idx + 8'd1);
                f_bd  <= 1'b1;
                state <= ST_BDWAIT;
              end
              ST_PEC: begin
                if (rw) pec_r <= bus_rbyte;
                state <= ST_STOP;
              end
              ST_STOP: begin
                busy  <= 1'b0;
                state <= ST_IDLE;
                if (nack_seen) f_dev  <= 1'b1;
                else           f_intr <= 1'b1;
              end
              default: state <= ST_IDLE;
            endcase
          end
        end
      end
    end
  end
endmodule

module smbus_host_ctrl_chk #(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_we,
  input logic [AW-1:0] reg_addr,
  input logic [7:0]    reg_wdata,
  input logic          irq,
  input logic          busy,
  input logic          pend,
  input logic          bus_op_valid,
  input logic          bus_op_done,
  input logic          bus_arb_lost
);
  logic ctl_w;
  assign ctl_w = reg_we && reg_addr == AW'(2);

  p_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_w && reg_wdata[6] && !reg_wdata[1] && !busy && reg_wdata[4:2] != 3'd4 && reg_wdata[4:2] != 3'd7) |=> busy);

  p_bad_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_w && !busy && (reg_wdata[4:2] == 3'd4 || reg_wdata[4:2] == 3'd7)) |=> !busy);

  p_one_op_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_op_valid |=> !bus_op_valid);

  p_quiet_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bus_op_valid);

  p_end_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> irq);

  p_arb_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && pend && bus_op_done && bus_arb_lost) |=> (!busy && irq));

  p_kill_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_w && reg_wdata[1] && busy) |=> (!busy && irq && !bus_op_valid));
endmodule

bind smbus_host_ctrl smbus_host_ctrl_chk #(.AW(AW)) u_chk (.*);

// File: tb/smbus_host_ctrl_tb.sv
`timescale 1ns/100ps
module smbus_host_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq, bus_op_valid, bus_rd_nack;
  logic [1:0] bus_op;
  logic [7:0] bus_wbyte;
  logic       bus_op_done = 1'b0, bus_ack = 1'b0, bus_arb_lost = 1'b0;
  logic [7:0] bus_rbyte = '0;

  always #2.5 clk = ~clk;

  smbus_host_ctrl #(.AW(4)) u_dut (.*);

  int n_tests = 0, n_fail = 0, cyc = 0;

  // engine model and trace
  logic [10:0] tr [0:1023];
  int tcnt = 0, rcnt = 0, dly = 0;
  int t0 = 0, rbase = 0, nack_at = -1, arb_at = -1, len_val = 0;
  bit len_mode = 0;
  logic p_ack = 1'b0, p_arb = 1'b0;
  logic [7:0] p_rb = '0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    bus_op_done <= 1'b0;
    if (dly != 0) begin
      dly <= dly - 1;
      if (dly == 1) begin
        bus_op_done <= 1'b1; bus_ack <= p_ack; bus_arb_lost <= p_arb; bus_rbyte <= p_rb;
      end
    end
    if (bus_op_valid) begin
      tr[tcnt & 1023] <= {bus_op, bus_rd_nack, bus_wbyte};
      p_ack <= (tcnt - t0) != nack_at;
      p_arb <= (tcnt - t0) == arb_at;
      if (bus_op == 2'd2) begin
        p_rb <= (rcnt == rbase && len_mode) ? 8'(len_val) : 8'(8'h50 + rcnt - rbase);
        rcnt <= rcnt + 1;
      end else p_rb <= 8'h00;
      tcnt <= tcnt + 1;
      dly  <= 2;
    end
  end

  always @(posedge clk) if (cyc == 150000) begin
    n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); reg_we = 1'b1; reg_addr = 4'(a); reg_wdata = 8'(d);
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    @(negedge clk); reg_addr = 4'(a); #1 d = reg_rdata;
  endtask

  logic [10:0] ex [0:63];
  int ecnt;
  task automatic push(input int op, input int nk, input int b);
    ex[ecnt] = {2'(op), 1'(nk), 8'(b)}; ecnt++;
  endtask

  task automatic build(input int p, input bit rw, input bit pe, input int n);
    bit pa;
    pa = pe && p != 0 && p != 6;
    ecnt = 0;
    push(0, 0, 0);
    push(1, 0, {7'h3C, (p <= 1) ? rw : 1'b0});
    if (p != 0) begin
      if (p == 1) begin
        if (rw) push(2, !pa, 0); else push(1, 0, 8'hC3);
      end else begin
        push(1, 0, (p == 6 && rw) ? 8'h22 : 8'hC3);
        if (rw) begin
          push(0, 0, 0); push(1, 0, {7'h3C, 1'b1});
          if (p == 3) push(2, 0, 0);
          if (p == 2 || p == 3) push(2, !pa, 0);
          if (p == 5) push(2, 0, 0);
          if (p >= 5) for (int i = 0; i < n; i++) push(2, (i == n - 1) && !pa, 0);
        end else begin
          if (p == 2 || p == 3) push(1, 0, 8'h11);
          if (p == 3) push(1, 0, 8'h22);
          if (p == 5) push(1, 0, n);
          if (p >= 5) for (int i = 0; i < n; i++) push(1, 0, 8'h30 + i);
        end
      end
      if (pa) begin
        if (rw) push(2, 1, 0); else push(1, 0, 8'hE7);
      end
    end
    push(3, 0, 0);
  endtask

  task automatic run(input int p, input bit rw, input bit pe, input int n, input int exp_sts);
    logic [7:0] s, v;
    int k, guard;
    string tg;
    tg = (p >= 5) ? ((p == 5) ? "R7" : "R8") : "R4";
    t0 = tcnt; rbase = rcnt; len_mode = (p == 5) && rw; len_val = n;
    wr(4, {7'h3C, rw}); wr(3, 8'hC3); wr(5, (p >= 5) ? n : 8'h11);
    wr(6, 8'h22); wr(7, 8'h30); wr(8, 8'hE7); wr(13, {7'b0, pe});
    wr(2, (p << 2) | 8'h40 | (pe ? 8'h80 : 8'h00));
    rd(0, s);
    chk("R3 busy after start", int'(s[0]), 1);
    k = 0; guard = 0;
    forever begin
      rd(0, s);
      if (s[7]) begin
        if (rw) begin
          rd(7, v);
          chk({tg, " block byte"}, v, 8'h50 + k + ((p == 5) ? 1 : 0));
        end else wr(7, 8'h31 + k);
        k++;
        wr(0, 8'h80);
      end else if (!s[0]) break;
      guard++;
      if (guard > 3000) break;
    end
    chk("R6 R10 R11 final status", s, exp_sts);
    if (p >= 5 && exp_sts == 2) chk({tg, " byte done count"}, k, n);
  endtask

  task automatic cmp_trace(input int p, input bit rw, input bit pe, input int n);
    string tg;
    tg = (p >= 5) ? ((p == 5) ? "R7" : "R8") : "R4";
    if (pe) tg = {tg, " R9"};
    build(p, rw, pe, n);
    chk({tg, " op count"}, tcnt - t0, ecnt);
    for (int i = 0; i < ecnt && i < tcnt - t0; i++)
      chk({tg, " op entry"}, tr[(t0 + i) & 1023], ex[i]);
  endtask

  task automatic clear_flags(input int exp_sts);
    logic [7:0] s;
    wr(0, 8'h00); rd(0, s);
    chk("R13 write 0 keeps flags", s, exp_sts);
    chk("R13 irq while flag set", int'(irq), 1);
    wr(0, 8'hFF); rd(0, s);
    chk("R13 write 1 clears", s, 0);
    chk("R13 irq low after clear", int'(irq), 0);
  endtask

  initial begin
    logic [7:0] v;
    int tc, nr;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R2 reset state
    rd(0, v); chk("R2 status after reset", v, 0);
    rd(2, v); chk("R2 control after reset", v, 0);
    chk("R2 irq after reset", int'(irq), 0);
    chk("R2 no bus op", int'(bus_op_valid), 0);
    // R1 register map
    wr(3, 8'hA5); rd(3, v); chk("R1 command readback", v, 8'hA5);
    wr(13, 8'hFF); rd(13, v); chk("R1 aux keeps bits 1:0", v, 8'h03);
    wr(2, 8'h9C); rd(2, v); chk("R1 control readback", v, 8'h9C);
    wr(10, 8'h77); rd(10, v); chk("R1 unmapped reads 0", v, 0);
    tc = tcnt;
    wr(2, 8'hFF); rd(2, v); chk("R1 control masks start and kill", v, 8'hBC);
    rd(0, v); chk("R3 code 7 start ignored", v, 0);
    wr(2, 8'h50); rd(0, v); chk("R3 code 4 start ignored", v, 0);
    chk("R3 no ops on bad code", tcnt - tc, 0);
    wr(2, 8'h00);

    // sweep of short protocols
    for (int p = 0; p < 4; p++)
      for (int rw = 0; rw < 2; rw++)
        for (int pe = 0; pe < 2; pe++) begin
          run(p, 1'(rw), 1'(pe), 0, 2);
          cmp_trace(p, 1'(rw), 1'(pe), 0);
          if (rw && p != 0) begin
            rd(5, v); chk("R5 data0 result", v, 8'h50);
            if (p == 3) begin rd(6, v); chk("R5 word high byte in data1", v, 8'h51); end
            if (pe) begin
              rd(8, v); chk("R9 PEC byte captured", v, (p == 3) ? 8'h52 : 8'h51);
            end
          end
          clear_flags(2);
        end

    // block and I2C block
    for (int p = 5; p < 7; p++)
      for (int rw = 0; rw < 2; rw++)
        for (int pe = 0; pe < 2; pe++)
          for (int n = 1; n <= 3; n += 2) begin
            run(p, 1'(rw), 1'(pe), n, 2);
            cmp_trace(p, 1'(rw), 1'(pe), n);
            if (p == 5 && rw) begin
              rd(5, v); chk("R7 length in data0", v, n);
              if (pe) begin
                nr = n + 1;
                rd(8, v); chk("R9 block PEC captured", v, 8'h50 + nr);
              end
            end
            clear_flags(2);
          end

    // R10 no acknowledge on address byte
    nack_at = 1;
    run(2, 1'b0, 1'b0, 0, 4);
    chk("R10 ops after nack", tcnt - t0, 3);
    chk("R10 stop issued", int'(tr[(t0 + 2) & 1023][10:9]), 3);
    nack_at = -1;
    clear_flags(4);

    // R11 arbitration lost on command byte
    arb_at = 2;
    run(2, 1'b0, 1'b0, 0, 8);
    chk("R11 ops after arb loss", tcnt - t0, 3);
    chk("R11 no stop", int'(tr[(t0 + 2) & 1023][10:9]), 1);
    arb_at = -1;
    clear_flags(8);

    // R3 start while busy, R12 kill during byte-done stall
    t0 = tcnt; rbase = rcnt; len_mode = 0;
    wr(4, 8'h78); wr(5, 2); wr(7, 8'h30); wr(13, 0);
    wr(2, 8'h54);
    for (int g = 0; g < 200; g++) begin
      rd(0, v);
      if (v[7]) break;
    end
    chk("R7 stall with byte done", v, 8'h81);
    tc = tcnt;
    wr(2, 8'h40);
    repeat (8) @(negedge clk);
    chk("R3 start while busy issues nothing", tcnt - tc, 0);
    rd(2, v); chk("R3 control unchanged while busy", v, 8'h14);
    wr(2, 8'h02);
    rd(0, v); chk("R12 kill status", v, 8'h90);
    chk("R12 irq after kill", int'(irq), 1);
    repeat (8) @(negedge clk);
    chk("R12 no ops after kill", tcnt - tc, 0);
    wr(0, 8'h90); rd(0, v); chk("R13 clear after kill", v, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule